// File: doc/BRIEF.md
# Add/Subtract Unit with Status Flags

This block is the arithmetic core of a small execution datapath. It adds or subtracts two operands, optionally folding a carry or borrow input into the sum, and derives five status flags from the outcome: carry (which serves as borrow when subtracting), parity, zero, sign and signed overflow. The operand width is chosen per operation: either the full 16-bit word or only its low byte.

The result and the flags are combinational. They are valid in the same cycle the operands arrive. A flag register captures the flag word on a clock edge when the update enable is high, so an instruction can choose whether it changes the stored condition codes.

Top module: `alu_flag_gen`

## Requirements
- R1: With `op_i` = 2'b00 (add) the result is `a_i + b_i` modulo 2^w, where w is 16 when `wide_i` = 1 and 8 when `wide_i` = 0. With `op_i` = 2'b01 (add with carry) the result is `a_i + b_i + cin_i` modulo 2^w.
- R2: With `op_i` = 2'b10 (subtract) the result is `a_i - b_i` modulo 2^w. With `op_i` = 2'b11 (subtract with borrow) the result is `a_i - b_i - cin_i` modulo 2^w.
- R3: Flag bit 0 (carry) is set on a carry out of bit w-1 when adding. When subtracting it is set when a borrow is needed, that is when the unsigned minuend is smaller than the subtrahend plus the borrow in. An 8-bit add of FFh and 01h gives 00h with bit 0 set. An 8-bit subtract of 01h from 00h gives FFh with bit 0 set.
- R4: Flag bit 1 (parity) is set when result bits 7:0 hold an even number of ones, at both widths.
- R5: Flag bit 2 (zero) is set when the low w bits of the result are all zero.
- R6: Flag bit 3 (sign) equals result bit w-1.
- R7: Flag bit 4 (overflow) is set when the true signed result of the operation lies outside the range of a w-bit two's complement number.
- R8: With `wide_i` = 0, result bits 15:8 are zero, and operand bits 15:8 affect neither the result nor the flags.
- R9: `flag_q_o` takes the value of `flags_o` at a rising clock edge where `flag_we_i` = 1, and keeps its value at every edge where `flag_we_i` = 0.
- R10: A synchronous active-high `rst` clears `flag_q_o` to zero.
- R11: `cin_i` has no effect on the result or the flags when `op_i` selects plain add or plain subtract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 2 | Operation: 00 add, 01 add with carry, 10 subtract, 11 subtract with borrow |
| wide_i | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| a_i | input | 16 | First operand (minuend) |
| b_i | input | 16 | Second operand (subtrahend) |
| cin_i | input | 1 | Carry or borrow input |
| flag_we_i | input | 1 | Flag register update enable |
| res_o | output | 16 | Result |
| flags_o | output | 5 | Current flags: bit 0 carry, 1 parity, 2 zero, 3 sign, 4 overflow |
| flag_q_o | output | 5 | Registered flags, same bit layout |

## Verification
On every cycle, the assertions check that parity, zero and sign agree with the result at the selected width. They also check that the upper result byte is clear in byte mode and that the flag register loads, holds or clears as R9 and R10 require. Carry, overflow and the arithmetic value itself can only be judged against independently computed sums, so the bench supplies those checks. It sweeps every low-byte minuend against a spread of subtrahends in all four operations, with noise in the unused upper operand bytes. It then crosses a set of 16-bit boundary values such as 7FFFh, 8000h and FFFFh with pseudo-random words.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_ADC = 2'b01,
        OP_SUB = 2'b10,
        OP_SBB = 2'b11
    } alu_op_e;

    // Packed so that bit 0 is carry and bit 4 is overflow.
    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic par;
        logic cry;
    } flag_word_t;

    typedef struct packed {
        logic carry_out;  // carry out of the active top bit
        logic carry_top;  // carry into the active top bit
        logic is_sub;
    } carry_info_t;

    function automatic logic even_ones(input logic [BYTE_W-1:0] v);
        return ~(^v);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_flag_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int BW = BYTE_W
) (
    input  alu_op_e       op,
    input  logic          wide,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic          cin,
    output logic [W-1:0]  res,
    output carry_info_t   cinfo
);
    localparam int HI_W = W - BW;

    logic          sub;
    logic          use_cin;
    logic          c0;
    logic [W-1:0]  b_eff;
    logic [W:0]    sum;
    logic          lo_out;
    logic          lo_in;
    logic          hi_out;
    logic          hi_in;

    always_comb begin
        sub     = (op == OP_SUB) || (op == OP_SBB);
        use_cin = (op == OP_ADC) || (op == OP_SBB);
        b_eff   = sub ? ~b : b;
        // Subtraction is a + ~b + 1, with the borrow in taking away that 1.
        c0      = sub ? ~(use_cin & cin) : (use_cin & cin);
        sum     = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c0};
        // A carry into bit i is recovered as sum[i] ^ a[i] ^ b_eff[i].
        hi_out  = sum[W];
        hi_in   = sum[W-1] ^ a[W-1] ^ b_eff[W-1];
        lo_out  = sum[BW] ^ a[BW] ^ b_eff[BW];
        lo_in   = sum[BW-1] ^ a[BW-1] ^ b_eff[BW-1];
        if (wide) begin
            res             = sum[W-1:0];
            cinfo.carry_out = hi_out;
            cinfo.carry_top = hi_in;
        end else begin
            res             = {{HI_W{1'b0}}, sum[BW-1:0]};
            cinfo.carry_out = lo_out;
            cinfo.carry_top = lo_in;
        end
        cinfo.is_sub = sub;
    end

endmodule

// File: rtl/alu_flag_calc.sv
module alu_flag_calc
    import alu_flag_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int BW = BYTE_W
) (
    input  logic [W-1:0] res,
    input  logic         wide,
    input  carry_info_t  cinfo,
    output flag_word_t   flags
);
    logic lo_zero;
    logic hi_zero;

    always_comb begin
        lo_zero   = (res[BW-1:0] == '0);
        hi_zero   = (res[W-1:BW] == '0);
        flags.cry = cinfo.carry_out ^ cinfo.is_sub;
        flags.par = even_ones(res[BW-1:0]);
        flags.zro = wide ? (lo_zero & hi_zero) : lo_zero;
        flags.sgn = wide ? res[W-1] : res[BW-1];
        flags.ovf = cinfo.carry_out ^ cinfo.carry_top;
    end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import alu_flag_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  flag_word_t d,
    output flag_word_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= d;
        end
    end

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
    import alu_flag_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int BW = BYTE_W,
    localparam int FW = $bits(flag_word_t)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    op_i,
    input  logic          wide_i,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  logic          cin_i,
    input  logic          flag_we_i,
    output logic [W-1:0]  res_o,
    output logic [FW-1:0] flags_o,
    output logic [FW-1:0] flag_q_o
);
    carry_info_t cinfo;
    flag_word_t  fl_now;
    flag_word_t  fl_reg;

    alu_addsub #(.W(W), .BW(BW)) u_addsub (
        .op    (alu_op_e'(op_i)),
        .wide  (wide_i),
        .a     (a_i),
        .b     (b_i),
        .cin   (cin_i),
        .res   (res_o),
        .cinfo (cinfo)
    );

    alu_flag_calc #(.W(W), .BW(BW)) u_calc (
        .res   (res_o),
        .wide  (wide_i),
        .cinfo (cinfo),
        .flags (fl_now)
    );

    alu_flag_reg u_freg (
        .clk (clk),
        .rst (rst),
        .we  (flag_we_i),
        .d   (fl_now),
        .q   (fl_reg)
    );

    assign flags_o  = fl_now;
    assign flag_q_o = fl_reg;

endmodule

// File: rtl/alu_flag_chk.sv
module alu_flag_chk #(
    parameter int W  = 16,
    parameter int BW = 8,
    parameter int FW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          wide_i,
    input logic          flag_we_i,
    input logic [W-1:0]  res_o,
    input logic [FW-1:0] flags_o,
    input logic [FW-1:0] flag_q_o
);
    AST_BYTE_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !wide_i |-> (res_o[W-1:BW] == '0)); // R8

    AST_PARITY_LOW_BYTE: assert property (@(posedge clk) disable iff (rst)
        flags_o[1] == ~(^res_o[BW-1:0])); // R4

    AST_ZERO_AT_WIDTH: assert property (@(posedge clk) disable iff (rst)
        flags_o[2] == (wide_i ? (res_o == '0) : (res_o[BW-1:0] == '0))); // R5

    AST_SIGN_AT_WIDTH: assert property (@(posedge clk) disable iff (rst)
        flags_o[3] == (wide_i ? res_o[W-1] : res_o[BW-1])); // R6

    AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (rst)
        flag_we_i |=> (flag_q_o == $past(flags_o))); // R9

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !flag_we_i |=> $stable(flag_q_o)); // R9

    AST_FLAG_RESET: assert property (@(posedge clk)
        rst |=> (flag_q_o == '0)); // R10

endmodule

bind alu_flag_gen alu_flag_chk #(.W(W), .BW(BW), .FW(FW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wide_i    (wide_i),
    .flag_we_i (flag_we_i),
    .res_o     (res_o),
    .flags_o   (flags_o),
    .flag_q_o  (flag_q_o)
);

// File: tb/sim_alu_flag_gen.sv
module sim_alu_flag_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  op_i = 2'b00;
    logic        wide_i = 1'b0;
    logic [15:0] a_i = '0;
    logic [15:0] b_i = '0;
    logic        cin_i = 1'b0;
    logic        flag_we_i = 1'b0;
    logic [15:0] res_o;
    logic [4:0]  flags_o;
    logic [4:0]  flag_q_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    alu_flag_gen u0 (
        .clk(clk), .rst(rst), .op_i(op_i), .wide_i(wide_i),
        .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .flag_we_i(flag_we_i),
        .res_o(res_o), .flags_o(flags_o), .flag_q_o(flag_q_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (op=%0d wide=%0d a=%h b=%h cin=%0d)",
                     req, act, exp, op_i, wide_i, a_i, b_i, cin_i);
        end
    endtask

    function automatic int sx(input int v, input int w);
        return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
    endfunction

    function automatic int parity_even(input int v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (v >> i) & 1;
        return ((n % 2) == 0) ? 1 : 0;
    endfunction

    // Expected flag word: bit0 carry, bit1 parity, bit2 zero, bit3 sign, bit4 overflow
    function automatic int exp_flags(input int op, input int wide, input int a,
                                     input int b, input int cin, output int res);
        int w    = wide ? 16 : 8;
        int mask = (1 << w) - 1;
        int am   = a & mask;
        int bm   = b & mask;
        int ci   = (op == 1 || op == 3) ? cin : 0;
        int r, s, cf, of, zf, sf, pf;
        if (op < 2) begin
            r  = am + bm + ci;
            cf = (r >> w) & 1;
            s  = sx(am, w) + sx(bm, w) + ci;
        end else begin
            r  = am - bm - ci;
            cf = (r < 0) ? 1 : 0;
            s  = sx(am, w) - sx(bm, w) - ci;
        end
        res = r & mask;
        of  = (s > (1 << (w - 1)) - 1 || s < -(1 << (w - 1))) ? 1 : 0;
        zf  = (res == 0) ? 1 : 0;
        sf  = (res >> (w - 1)) & 1;
        pf  = parity_even(res & 8'hFF);
        return cf | (pf << 1) | (zf << 2) | (sf << 3) | (of << 4);
    endfunction

    task automatic run_vec(input int op, input int wide, input int a, input int b, input int cin);
        int er, ef;
        string rq;
        op_i   = op[1:0];
        wide_i = wide[0];
        a_i    = a[15:0];
        b_i    = b[15:0];
        cin_i  = cin[0];
        #1;
        ef = exp_flags(op, wide, a, b, cin, er);
        // R11: plain add/sub ignore cin, so the expected value ignores it too
        rq = (op < 2) ? ((op == 0) ? "R1/R11 result" : "R1 result")
                      : ((op == 2) ? "R2/R11 result" : "R2 result");
        if (!wide) rq = {rq, " R8"};
        chk(rq, int'(res_o), er);
        chk("R3 carry",    int'(flags_o[0]), ef & 1);
        chk("R4 parity",   int'(flags_o[1]), (ef >> 1) & 1);
        chk("R5 zero",     int'(flags_o[2]), (ef >> 2) & 1);
        chk("R6 sign",     int'(flags_o[3]), (ef >> 3) & 1);
        chk("R7 overflow", int'(flags_o[4]), (ef >> 4) & 1);
    endtask

    initial begin
        #(200000 * 10 - 100);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    int edges[10] = '{0, 1, 'h7F, 'h80, 'hFF, 'h100, 'h7FFF, 'h8000, 'hFFFE, 'hFFFF};

    initial begin
        int q_before;
        int seed;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R10 reset state", int'(flag_q_o), 0);
        rst = 1'b0;

        // Documented corner cases (R3)
        run_vec(0, 0, 'hFF, 'h01, 0);
        chk("R3 FF+01 result", int'(res_o), 0);
        chk("R3 FF+01 carry", int'(flags_o[0]), 1);
        run_vec(2, 0, 'h00, 'h01, 0);
        chk("R3 00-01 result", int'(res_o), 'hFF);
        chk("R3 00-01 borrow", int'(flags_o[0]), 1);

        @(negedge clk);
        q_before = int'(flag_q_o);
        // Byte sweep with garbage in the upper operand bytes (R8, R11)
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b += 5) begin
                for (int op = 0; op < 4; op++) begin
                    run_vec(op, 0, a | (((a * 7 + b) & 'hFF) << 8),
                            b | (((a ^ 'hA5) & 'hFF) << 8), (a + b + op) & 1);
                end
            end
        end
        // Word boundary cross
        foreach (edges[i]) begin
            foreach (edges[j]) begin
                for (int op = 0; op < 4; op++) begin
                    for (int c = 0; c < 2; c++) run_vec(op, 1, edges[i], edges[j], c);
                end
            end
        end
        // Word pseudo-random
        seed = 'h1D3A;
        for (int k = 0; k < 2500; k++) begin
            int x, y;
            seed = (seed * 1103515245 + 12345) & 'h7FFFFFFF;
            x = (seed >> 8) & 'hFFFF;
            seed = (seed * 1103515245 + 12345) & 'h7FFFFFFF;
            y = (seed >> 8) & 'hFFFF;
            run_vec(k % 4, 1, x, y, (seed >> 3) & 1);
        end
        @(negedge clk);
        chk("R9 hold during sweep", int'(flag_q_o), q_before);

        // Register load and hold
        run_vec(0, 0, 'hFF, 'h01, 0);   // flags: carry, parity, zero = 5'b00111
        flag_we_i = 1'b1;
        @(negedge clk);
        chk("R9 load", int'(flag_q_o), 'h07);
        flag_we_i = 1'b0;
        run_vec(0, 0, 'h01, 'h01, 0);   // flags now 0
        repeat (2) @(negedge clk);
        chk("R9 hold", int'(flag_q_o), 'h07);
        run_vec(0, 1, 'h7FFF, 'h0001, 0); // 8000h: sign, overflow, parity = 5'b11010
        flag_we_i = 1'b1;
        @(negedge clk);
        chk("R9 load word", int'(flag_q_o), 'h1A);
        flag_we_i = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk("R10 reset clears", int'(flag_q_o), 0);
        rst = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule